// File: doc/BRIEF.md
# SIMD Lane Register and ALU Datapath

One lane of a four-lane SIMD array whose lanes run in lockstep. The lane holds a 32-entry, 32-bit register file and a single ALU. Every cycle a shared decoder presents the same operation code, three register indices and a 14-bit immediate to all lanes. Each lane then runs the operation on its own registers: arithmetic, bitwise logic, signed compares, an arithmetic right shift by an immediate, add-immediate, a conditional move and a load from a per-lane pseudo-random source.

A side port lets the lane's buffer slot read any register and write any register. A zero flag reports whether a selected register holds zero. Outside the lane, these flags are combined across all lanes to decide a branch. Register writes land on the rising clock edge. All reads are combinational.

Top module: `simd_lane`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 32'h0.
- R2: When buf_we_i is high, buf_wdata_i is written into R[buf_idx_i] at the clock edge. buf_rdata_o always shows R[buf_idx_i] combinationally. A buffer write takes precedence, so in that cycle no ALU result is written and the random source does not advance.
- R3: Op codes 1 (add), 2 (sub) and 3 (mul) write R[rs1] + R[rs2], R[rs1] - R[rs2] and the low 32 bits of R[rs1] * R[rs2] into R[rd]. All three wrap modulo 2^32.
- R4: Op codes 4 (and), 5 (or) and 6 (xor) write the bitwise result of R[rs1] and R[rs2] into R[rd].
- R5: Op code 7 (addi) writes R[rs1] plus the sign-extended 14-bit immediate into R[rd]. Immediate 14'h3FFF means -1.
- R6: Op code 8 (ashr) writes R[rs1] shifted right by imm_i[4:0] into R[rd]. The sign bit is copied into the vacated positions.
- R7: Op codes 9 (lt), 10 (le) and 11 (eq) compare R[rs1] with R[rs2] as signed two's-complement values. They write exactly 32'd1 when the relation holds and 32'd0 otherwise into R[rd].
- R8: Op code 12 (conditional move) writes R[rs2] into R[rs1] when R[rd] is nonzero. When R[rd] is zero, no register changes.
- R9: Op code 13 (rnd) writes the current random state into R[rd]. The state then steps to {s[30:0], s[31]^s[21]^s[1]^s[0]}. It starts at the nonzero LANE_SEED after reset and holds in all other cycles.
- R10: zero_o is 1 exactly when R[zero_idx_i] equals zero, evaluated combinationally.
- R11: Op codes 0, 14 and 15 write no register.
- R12: Sources are read before the write. An operation whose destination is also a source uses the register's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code from the shared decoder |
| rd_idx_i | input | 5 | Destination index; condition register for the conditional move |
| rs1_idx_i | input | 5 | First source index; destination for the conditional move |
| rs2_idx_i | input | 5 | Second source index |
| imm_i | input | 14 | Immediate, sign-extended |
| buf_we_i | input | 1 | Buffer slot writes a register |
| buf_idx_i | input | 5 | Register index for the buffer port |
| buf_wdata_i | input | 32 | Data from the buffer slot |
| buf_rdata_o | output | 32 | R[buf_idx_i] to the buffer slot |
| zero_idx_i | input | 5 | Register tested by the zero flag |
| zero_o | output | 1 | R[zero_idx_i] is zero |

## Verification
The arithmetic ops are driven with operands that sit at the signed overflow boundary and with products whose high bits are lost. This shows whether the lane wraps modulo 2^32 or saturates. The compares use a negative value against a positive one and also two equal values. The first pattern tells signed ordering from unsigned ordering; the second separates lt from le. The shift and add-immediate tests use negative inputs to show whether sign extension is applied. The conditional move is tried with a zero condition and with a nonzero condition. Buffer writes issued together with an ALU op, and destinations that alias a source, show whether the write priority and the read-before-write order are correct.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_ADDI = 4'd7,
    OP_ASHR = 4'd8,
    OP_LT   = 4'd9,
    OP_LE   = 4'd10,
    OP_EQ   = 4'd11,
    OP_MVT  = 4'd12,
    OP_RND  = 4'd13
  } op_e;
endpackage

// File: rtl/lane_regfile.sv
module lane_regfile #(
  parameter int REG_N  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ra1_i,
  input  logic [IDX_W-1:0]  ra2_i,
  input  logic [IDX_W-1:0]  ra3_i,
  input  logic [IDX_W-1:0]  rab_i,
  input  logic [IDX_W-1:0]  raz_i,
  output logic [DATA_W-1:0] rd1_o,
  output logic [DATA_W-1:0] rd2_o,
  output logic [DATA_W-1:0] rd3_o,
  output logic [DATA_W-1:0] rdb_o,
  output logic [DATA_W-1:0] rdz_o
);
  logic [REG_N-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem <= '0;
    else if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rd1_o = mem[ra1_i];
  assign rd2_o = mem[ra2_i];
  assign rd3_o = mem[ra3_i];
  assign rdb_o = mem[rab_i];
  assign rdz_o = mem[raz_i];

  // R2: a requested write lands at the addressed entry
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
  // R11: without a write the whole file holds
  a_r11_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem == $past(mem));
endmodule

// File: rtl/lane_lfsr.sv
module lane_lfsr #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] SEED   = 32'h1357_9BDF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [DATA_W-1:0] state_o
);
  logic [31:0] state;
  logic        fb;

  assign fb = state[31] ^ state[21] ^ state[1] ^ state[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state <= SEED;
    else if (step_i) state <= {state[30:0], fb};
  end

  generate
    if (DATA_W <= 32) begin : g_trunc
      assign state_o = state[DATA_W-1:0];
    end else begin : g_ext
      assign state_o = {{(DATA_W-32){1'b0}}, state};
    end
  endgenerate

  a_r9_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != 32'h0);
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state));
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import simd_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] cond_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] rnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o
);
  logic [2*DATA_W-1:0] prod;
  assign prod = a_i * b_i;

  always_comb begin
    res_o = '0;
    we_o  = 1'b1;
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = prod[DATA_W-1:0];
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_ADDI: res_o = a_i + imm_i;
      OP_ASHR: res_o = DATA_W'($signed(a_i) >>> imm_i[SH_W-1:0]);
      OP_LT:   res_o = DATA_W'($signed(a_i) <  $signed(b_i));
      OP_LE:   res_o = DATA_W'($signed(a_i) <= $signed(b_i));
      OP_EQ:   res_o = DATA_W'(a_i == b_i);
      OP_MVT: begin
        res_o = b_i;
        we_o  = (cond_i != '0);
      end
      OP_RND:  res_o = rnd_i;
      default: we_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_lane_pkg::*;
#(
  parameter int          REG_N     = 32,
  parameter int          DATA_W    = 32,
  parameter int          IMM_W     = 14,
  parameter logic [31:0] LANE_SEED = 32'h1357_9BDF,
  localparam int         IDX_W     = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  rs1_idx_i,
  input  logic [IDX_W-1:0]  rs2_idx_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              buf_we_i,
  input  logic [IDX_W-1:0]  buf_idx_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  input  logic [IDX_W-1:0]  zero_idx_i,
  output logic              zero_o
);
  op_e               op;
  logic [DATA_W-1:0] src_a, src_b, src_c, zdata, imm_ext, rnd, alu_res;
  logic              alu_we, rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  assign op      = op_e'(op_i);
  assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  lane_regfile #(.REG_N(REG_N), .DATA_W(DATA_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .ra1_i(rs1_idx_i), .ra2_i(rs2_idx_i), .ra3_i(rd_idx_i),
    .rab_i(buf_idx_i), .raz_i(zero_idx_i),
    .rd1_o(src_a), .rd2_o(src_b), .rd3_o(src_c),
    .rdb_o(buf_rdata_o), .rdz_o(zdata)
  );

  lane_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(op), .a_i(src_a), .b_i(src_b), .cond_i(src_c),
    .imm_i(imm_ext), .rnd_i(rnd), .res_o(alu_res), .we_o(alu_we)
  );

  lane_lfsr #(.DATA_W(DATA_W), .SEED(LANE_SEED)) u_rng (
    .clk_i, .rst_ni,
    .step_i(op == OP_RND && !buf_we_i),
    .state_o(rnd)
  );

  // buffer slot has priority over the ALU write port
  always_comb begin
    if (buf_we_i) begin
      rf_we    = 1'b1;
      rf_waddr = buf_idx_i;
      rf_wdata = buf_wdata_i;
    end else begin
      rf_we    = alu_we;
      rf_waddr = (op == OP_MVT) ? rs1_idx_i : rd_idx_i;
      rf_wdata = alu_res;
    end
  end

  assign zero_o = (zdata == '0);

  a_r8_mvt_false_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_MVT && !buf_we_i && src_c == '0) |-> !rf_we);
  a_r11_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 || op_i == 4'd14 || op_i == 4'd15) && !buf_we_i |-> !rf_we);
endmodule

// File: tb/simd_lane_tb.sv
module simd_lane_tb;
  localparam logic [31:0] SEED = 32'hC0FF_EE01;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [4:0]  rd_idx_i = '0, rs1_idx_i = '0, rs2_idx_i = '0;
  logic [13:0] imm_i = '0;
  logic        buf_we_i = 1'b0;
  logic [4:0]  buf_idx_i = '0;
  logic [31:0] buf_wdata_i = '0;
  logic [31:0] buf_rdata_o;
  logic [4:0]  zero_idx_i = '0;
  logic        zero_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] rng;

  always #2 clk = ~clk;

  simd_lane #(.LANE_SEED(SEED)) u_dut (
    .clk_i(clk), .rst_ni, .op_i, .rd_idx_i, .rs1_idx_i, .rs2_idx_i, .imm_i,
    .buf_we_i, .buf_idx_i, .buf_wdata_i, .buf_rdata_o, .zero_idx_i, .zero_o
  );

  function automatic logic [31:0] rng_next(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [4:0] idx, logic [31:0] exp);
    buf_idx_i = idx;
    #0.5;
    check(req, buf_rdata_o, exp);
  endtask

  task automatic wr(logic [4:0] idx, logic [31:0] d);
    @(negedge clk);
    buf_we_i = 1'b1; buf_idx_i = idx; buf_wdata_i = d;
    @(negedge clk);
    buf_we_i = 1'b0;
  endtask

  task automatic exec(logic [3:0] op, logic [4:0] rd, logic [4:0] r1, logic [4:0] r2,
                      logic [13:0] imm);
    @(negedge clk);
    op_i = op; rd_idx_i = rd; rs1_idx_i = r1; rs2_idx_i = r2; imm_i = imm;
    @(negedge clk);
    op_i = 4'd0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) rd_chk("R1 reset", 5'(i), 32'h0);
    zero_idx_i = 5'd17; #0.5;
    check("R10 zero after reset", 32'(zero_o), 32'd1);
  endtask

  task automatic t_buf();
    wr(5'd5, 32'hDEAD_BEEF);
    rd_chk("R2 buffer write", 5'd5, 32'hDEAD_BEEF);
    zero_idx_i = 5'd5; #0.5;
    check("R10 nonzero flag", 32'(zero_o), 32'd0);
    zero_idx_i = 5'd6; #0.5;
    check("R10 zero flag", 32'(zero_o), 32'd1);
  endtask

  task automatic t_arith();
    wr(5'd1, 32'h7FFF_FFFF); wr(5'd2, 32'h1);
    exec(4'd1, 5'd3, 5'd1, 5'd2, '0); rd_chk("R3 add wrap", 5'd3, 32'h8000_0000);
    exec(4'd2, 5'd3, 5'd2, 5'd1, '0); rd_chk("R3 sub", 5'd3, 32'h8000_0002);
    wr(5'd1, 32'h0001_0001); wr(5'd2, 32'h0001_0000);
    exec(4'd3, 5'd3, 5'd1, 5'd2, '0); rd_chk("R3 mul low bits", 5'd3, 32'h0001_0000);
    wr(5'd1, 32'd7); wr(5'd2, 32'hFFFF_FFFD);
    exec(4'd3, 5'd3, 5'd1, 5'd2, '0); rd_chk("R3 mul negative", 5'd3, 32'hFFFF_FFEB);
  endtask

  task automatic t_logic();
    wr(5'd1, 32'hF0F0_1234); wr(5'd2, 32'h0FF0_FF00);
    exec(4'd4, 5'd4, 5'd1, 5'd2, '0); rd_chk("R4 and", 5'd4, 32'h00F0_1200);
    exec(4'd5, 5'd4, 5'd1, 5'd2, '0); rd_chk("R4 or",  5'd4, 32'hFFF0_FF34);
    exec(4'd6, 5'd4, 5'd1, 5'd2, '0); rd_chk("R4 xor", 5'd4, 32'hFF00_ED34);
  endtask

  task automatic t_imm();
    wr(5'd8, 32'd10);
    exec(4'd7, 5'd9, 5'd8, 5'd0, 14'h3FFF); rd_chk("R5 addi -1", 5'd9, 32'd9);
    exec(4'd7, 5'd9, 5'd8, 5'd0, 14'h1FFF); rd_chk("R5 addi max", 5'd9, 32'd8201);
    exec(4'd7, 5'd9, 5'd8, 5'd0, 14'h2000); rd_chk("R5 addi min", 5'd9, 32'hFFFF_E00A);
    wr(5'd8, 32'h8000_0010);
    exec(4'd8, 5'd9, 5'd8, 5'd0, 14'd4); rd_chk("R6 ashr negative", 5'd9, 32'hF800_0001);
    wr(5'd8, 32'h4000_0000);
    exec(4'd8, 5'd9, 5'd8, 5'd0, 14'd30); rd_chk("R6 ashr positive", 5'd9, 32'h1);
  endtask

  task automatic t_cmp();
    wr(5'd1, 32'hFFFF_FFFF); wr(5'd2, 32'd1);
    exec(4'd9,  5'd10, 5'd1, 5'd2, '0); rd_chk("R7 lt signed", 5'd10, 32'd1);
    exec(4'd10, 5'd10, 5'd2, 5'd1, '0); rd_chk("R7 le false",  5'd10, 32'd0);
    exec(4'd11, 5'd10, 5'd1, 5'd2, '0); rd_chk("R7 eq false",  5'd10, 32'd0);
    wr(5'd2, 32'hFFFF_FFFF);
    exec(4'd9,  5'd10, 5'd1, 5'd2, '0); rd_chk("R7 lt equal",  5'd10, 32'd0);
    exec(4'd10, 5'd10, 5'd1, 5'd2, '0); rd_chk("R7 le equal",  5'd10, 32'd1);
    exec(4'd11, 5'd10, 5'd1, 5'd2, '0); rd_chk("R7 eq true",   5'd10, 32'd1);
  endtask

  task automatic t_mvt();
    wr(5'd11, 32'd0); wr(5'd12, 32'h1111_1111); wr(5'd13, 32'h2222_2222);
    exec(4'd12, 5'd11, 5'd12, 5'd13, '0);
    rd_chk("R8 mvt false dest", 5'd12, 32'h1111_1111);
    rd_chk("R8 mvt false cond", 5'd11, 32'd0);
    wr(5'd11, 32'h8000_0000);
    exec(4'd12, 5'd11, 5'd12, 5'd13, '0);
    rd_chk("R8 mvt true", 5'd12, 32'h2222_2222);
  endtask

  task automatic t_rnd();
    rng = SEED;
    exec(4'd13, 5'd14, 5'd0, 5'd0, '0); rd_chk("R9 rnd first", 5'd14, rng);
    rng = rng_next(rng);
    exec(4'd1, 5'd15, 5'd1, 5'd2, '0);
    exec(4'd13, 5'd14, 5'd0, 5'd0, '0); rd_chk("R9 rnd second", 5'd14, rng);
    rng = rng_next(rng);
  endtask

  task automatic t_prio();
    wr(5'd20, 32'h5555_0000);
    @(negedge clk);
    op_i = 4'd13; rd_idx_i = 5'd20;
    buf_we_i = 1'b1; buf_idx_i = 5'd21; buf_wdata_i = 32'hABCD_0001;
    @(negedge clk);
    op_i = 4'd0; buf_we_i = 1'b0;
    rd_chk("R2 buffer wins", 5'd21, 32'hABCD_0001);
    rd_chk("R2 alu suppressed", 5'd20, 32'h5555_0000);
    exec(4'd13, 5'd20, 5'd0, 5'd0, '0);
    rd_chk("R2 rng not stepped", 5'd20, rng);
  endtask

  task automatic t_idle();
    wr(5'd22, 32'h0BAD_F00D);
    exec(4'd0,  5'd22, 5'd1, 5'd2, '0); rd_chk("R11 op0 idle", 5'd22, 32'h0BAD_F00D);
    exec(4'd14, 5'd22, 5'd1, 5'd2, '0); rd_chk("R11 op14 idle", 5'd22, 32'h0BAD_F00D);
    exec(4'd15, 5'd22, 5'd1, 5'd2, '0); rd_chk("R11 op15 idle", 5'd22, 32'h0BAD_F00D);
  endtask

  task automatic t_alias();
    wr(5'd23, 32'd21);
    exec(4'd1, 5'd23, 5'd23, 5'd23, '0); rd_chk("R12 alias add", 5'd23, 32'd42);
    exec(4'd7, 5'd23, 5'd23, 5'd0, 14'h3FFF); rd_chk("R12 alias dec", 5'd23, 32'd41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_buf();
    t_arith();
    t_logic();
    t_imm();
    t_cmp();
    t_mvt();
    t_rnd();
    t_prio();
    t_idle();
    t_alias();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule